// File: doc/BRIEF.md
# Copy-Engine Interrupt Hub

The hub collects interrupt events from eight copy engines and turns them into one shared interrupt line. Each engine reports copy-complete pulses, error pulses and the current occupancy of its source and destination rings. The hub compares each occupancy against a per-ring high/low watermark pair and raises a one-cycle event when the ring first reaches the high threshold or first drops to the low threshold.

Every event latches into a per-engine status register whether or not it is enabled. An engine's bit in the summary vector is high while any latched status bit has its enable set. Copy-complete and watermark bits are gated by the engine's main enable register, and the error bit by a separate error enable. Software clears status by writing a mask, and each bit clears on its own. The OR of the summary vector drives the shared interrupt output through one register.

A simple write-strobe port reaches all registers. Reads are combinational from the address.

Top module: `cpe_irq_hub`

## Requirements
- R1: After reset all enable, error-enable and status registers read zero, `summary` and `irq` are low, and each watermark register reads high field all ones and low field zero.
- R2: `reg_addr` is {engine, sel[2:0]}. sel 0 is the enable register: bit0 copy-complete, bit1 source high, bit2 source low, bit3 destination high, bit4 destination low. sel 1 is status, with the same bits plus bit5 error. sel 2 is error enable in bit0. sel 3 is the source watermark and sel 4 the destination watermark, each with the low field in [OCC_W-1:0] and the high field in [2*OCC_W-1:OCC_W]. Any other sel reads zero. Reads are combinational.
- R3: A `done_pulse` bit sampled high at a clock edge sets status bit0 of that engine at that edge, enabled or not.
- R4: An `err_pulse` bit sets status bit5 of that engine at the same edge, whatever the error enable holds.
- R5: A high-watermark status bit sets only on the cycle in which occupancy >= high becomes true. It sets once per crossing and not again while occupancy stays at or above the field.
- R6: A low-watermark status bit sets only on the cycle in which occupancy <= low becomes true.
- R7: A write to status clears exactly the bits set in the written mask, leaves the other bits unchanged, and never sets a bit.
- R8: An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R9: `summary[n]` is high exactly when engine n holds a status bit whose enable is set. The error bit is gated by error enable, the others by the enable register.
- R10: `irq` equals the OR of `summary` as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ENG_W+3 | Engine index and register select |
| reg_wdata | input | 2*OCC_W | Write data |
| reg_rdata | output | 2*OCC_W | Read data for `reg_addr` |
| done_pulse | input | NUM_ENG | Copy-complete event per engine |
| err_pulse | input | NUM_ENG | Error event per engine |
| src_occ | input | NUM_ENG*OCC_W | Source ring occupancy per engine |
| dst_occ | input | NUM_ENG*OCC_W | Destination ring occupancy per engine |
| summary | output | NUM_ENG | Engines with an enabled pending interrupt |
| irq | output | 1 | Shared registered interrupt |

## Verification
On every cycle the assertions check that an event latches its status bit regardless of enable, and that it survives a same-cycle clear. They also check that a clear without an event removes the bit, that a watermark event never fires on two consecutive cycles, and that the shared line lags the summary by exactly one clock. Only the bench scenarios can show the rest: the mapping of registers and bit positions, that a clear leaves untouched bits alone, that disabled bits stay out of the summary, and that a ring resting above its threshold produces no second event.

// File: rtl/cpe_irq_pkg.sv
package cpe_irq_pkg;
  localparam int SEL_W  = 3;
  localparam int EN_W   = 5;
  localparam int STAT_W = 6;

  localparam int B_DONE = 0;
  localparam int B_SHI  = 1;
  localparam int B_SLO  = 2;
  localparam int B_DHI  = 3;
  localparam int B_DLO  = 4;
  localparam int B_ERR  = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_EN    = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_ERREN = 3'd2,
    SEL_SWM   = 3'd3,
    SEL_DWM   = 3'd4
  } reg_sel_e;

  // Pending when any latched bit meets its own enable.
  function automatic logic is_pending(input logic [STAT_W-1:0] stat,
                                      input logic [EN_W-1:0]   en,
                                      input logic              err_en);
    return |(stat & {err_en, en});
  endfunction
endpackage

// File: rtl/cpe_wm_detect.sv
module cpe_wm_detect #(
  parameter int OCC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] hi_lvl,
  input  logic [OCC_W-1:0] lo_lvl,
  output logic             hi_evt,
  output logic             lo_evt
);
  function automatic logic reached_hi(input logic [OCC_W-1:0] o, input logic [OCC_W-1:0] h);
    return o >= h;
  endfunction

  function automatic logic reached_lo(input logic [OCC_W-1:0] o, input logic [OCC_W-1:0] l);
    return o <= l;
  endfunction

  logic above_now, below_now;
  logic above_q, below_q;

  assign above_now = reached_hi(occ, hi_lvl);
  assign below_now = reached_lo(occ, lo_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      below_q <= 1'b1;
    end else begin
      above_q <= above_now;
      below_q <= below_now;
    end
  end

  assign hi_evt = above_now & ~above_q;
  assign lo_evt = below_now & ~below_q;

  p_hi_once_r5: assert property (@(posedge clk) disable iff (!rst_n) hi_evt |=> !hi_evt);
  p_lo_once_r6: assert property (@(posedge clk) disable iff (!rst_n) lo_evt |=> !lo_evt);
endmodule

// File: rtl/cpe_engine_slice.sv
module cpe_engine_slice
  import cpe_irq_pkg::*;
#(
  parameter int OCC_W = 8,
  localparam int DW = 2 * OCC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic             done_evt,
  input  logic             err_evt,
  input  logic [OCC_W-1:0] src_occ,
  input  logic [OCC_W-1:0] dst_occ,
  output logic             pend
);
  logic [EN_W-1:0]   en_q;
  logic [STAT_W-1:0] stat_q;
  logic              erren_q;
  logic [DW-1:0]     swm_q, dwm_q;

  logic s_hi, s_lo, d_hi, d_lo;
  logic [STAT_W-1:0] set_vec, clr_vec;

  localparam logic [DW-1:0] WM_RST = {{OCC_W{1'b1}}, {OCC_W{1'b0}}};

  function automatic logic [OCC_W-1:0] hi_field(input logic [DW-1:0] v);
    return v[DW-1:OCC_W];
  endfunction

  function automatic logic [OCC_W-1:0] lo_field(input logic [DW-1:0] v);
    return v[OCC_W-1:0];
  endfunction

  cpe_wm_detect #(.OCC_W(OCC_W)) u_src (
    .clk(clk), .rst_n(rst_n), .occ(src_occ),
    .hi_lvl(hi_field(swm_q)), .lo_lvl(lo_field(swm_q)),
    .hi_evt(s_hi), .lo_evt(s_lo)
  );

  cpe_wm_detect #(.OCC_W(OCC_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .occ(dst_occ),
    .hi_lvl(hi_field(dwm_q)), .lo_lvl(lo_field(dwm_q)),
    .hi_evt(d_hi), .lo_evt(d_lo)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_DONE] = done_evt;
    set_vec[B_SHI]  = s_hi;
    set_vec[B_SLO]  = s_lo;
    set_vec[B_DHI]  = d_hi;
    set_vec[B_DLO]  = d_lo;
    set_vec[B_ERR]  = err_evt;
  end

  assign clr_vec = (wr_en && sel == SEL_STAT) ? wr_data[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      stat_q  <= '0;
      erren_q <= 1'b0;
      swm_q   <= WM_RST;
      dwm_q   <= WM_RST;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      if (wr_en) begin
        case (sel)
          SEL_EN:    en_q    <= wr_data[EN_W-1:0];
          SEL_ERREN: erren_q <= wr_data[0];
          SEL_SWM:   swm_q   <= wr_data;
          SEL_DWM:   dwm_q   <= wr_data;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_EN:    rd_data = DW'(en_q);
      SEL_STAT:  rd_data = DW'(stat_q);
      SEL_ERREN: rd_data = DW'(erren_q);
      SEL_SWM:   rd_data = swm_q;
      SEL_DWM:   rd_data = dwm_q;
      default:   rd_data = '0;
    endcase
  end

  assign pend = is_pending(stat_q, en_q, erren_q);

  p_done_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat_q[B_DONE]);
  p_err_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> stat_q[B_ERR]);
  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[B_DONE] && done_evt) |=> stat_q[B_DONE]);

  for (genvar b = 0; b < STAT_W; b++) begin : g_clr_chk
    p_clear_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[b] && !set_vec[b]) |=> !stat_q[b]);
  end
endmodule

// File: rtl/cpe_irq_hub.sv
module cpe_irq_hub
  import cpe_irq_pkg::*;
#(
  parameter int NUM_ENG = 8,
  parameter int OCC_W   = 8,
  localparam int ENG_W  = $clog2(NUM_ENG),
  localparam int DW     = 2 * OCC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ENG_W+SEL_W-1:0]   reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic [NUM_ENG-1:0]       done_pulse,
  input  logic [NUM_ENG-1:0]       err_pulse,
  input  logic [NUM_ENG*OCC_W-1:0] src_occ,
  input  logic [NUM_ENG*OCC_W-1:0] dst_occ,
  output logic [NUM_ENG-1:0]       summary,
  output logic                     irq
);
  logic [ENG_W-1:0] eng_idx;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    rd_arr [NUM_ENG];
  logic             any_pend;
  logic             irq_q;

  assign eng_idx = reg_addr[ENG_W+SEL_W-1:SEL_W];
  assign sel     = reg_addr[SEL_W-1:0];

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    logic wr_hit;
    assign wr_hit = reg_we && (eng_idx == ENG_W'(g));

    cpe_engine_slice #(.OCC_W(OCC_W)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_hit), .sel(sel), .wr_data(reg_wdata),
      .rd_data(rd_arr[g]),
      .done_evt(done_pulse[g]), .err_evt(err_pulse[g]),
      .src_occ(src_occ[g*OCC_W +: OCC_W]),
      .dst_occ(dst_occ[g*OCC_W +: OCC_W]),
      .pend(summary[g])
    );
  end

  assign reg_rdata = rd_arr[eng_idx];
  assign any_pend  = |summary;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend;
  end

  assign irq = irq_q;

  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(any_pend));
endmodule

// File: tb/tb_cpe_irq_hub.sv
module tb_cpe_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int OW = 8;
  localparam int AW = 6;
  localparam int DW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic [DW-1:0]  reg_rdata;
  logic [NE-1:0]  done_pulse = '0;
  logic [NE-1:0]  err_pulse = '0;
  logic [NE*OW-1:0] src_occ = '0;
  logic [NE*OW-1:0] dst_occ = '0;
  logic [NE-1:0]  summary;
  logic           irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpe_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_pulse(done_pulse), .err_pulse(err_pulse),
    .src_occ(src_occ), .dst_occ(dst_occ),
    .summary(summary), .irq(irq)
  );

  localparam logic [2:0] K_WR = 0, K_RD = 1, K_DONE = 2, K_ERR = 3,
                         K_SOCC = 4, K_DOCC = 5, K_SUM = 6;

  typedef struct packed {
    logic [2:0]  kind;
    logic [2:0]  eng;
    logic [2:0]  sel;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 37;
  localparam step_t TBL [NSTEP] = '{
    '{K_WR,   3'd2, 3'd0, 16'h0001, 16'h0000, 4'd9},  // R9 enable copy-complete
    '{K_DONE, 3'd2, 3'd0, 16'h0000, 16'h0000, 4'd3},
    '{K_RD,   3'd2, 3'd1, 16'h0000, 16'h0001, 4'd3},  // R3
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0004, 4'd9},  // R9
    '{K_WR,   3'd2, 3'd1, 16'h0001, 16'h0000, 4'd7},
    '{K_RD,   3'd2, 3'd1, 16'h0000, 16'h0000, 4'd7},  // R7
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0000, 4'd9},
    '{K_DONE, 3'd5, 3'd0, 16'h0000, 16'h0000, 4'd3},
    '{K_RD,   3'd5, 3'd1, 16'h0000, 16'h0001, 4'd3},  // R3 latched while disabled
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0000, 4'd9},  // R9 disabled bit ignored
    '{K_WR,   3'd5, 3'd3, 16'h0A03, 16'h0000, 4'd2},
    '{K_RD,   3'd5, 3'd3, 16'h0000, 16'h0A03, 4'd2},  // R2
    '{K_SOCC, 3'd5, 3'd0, 16'h000A, 16'h0000, 4'd5},
    '{K_RD,   3'd5, 3'd1, 16'h0000, 16'h0003, 4'd5},  // R5 reach high
    '{K_WR,   3'd5, 3'd0, 16'h0002, 16'h0000, 4'd9},
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0020, 4'd9},
    '{K_WR,   3'd5, 3'd1, 16'h0002, 16'h0000, 4'd7},
    '{K_RD,   3'd5, 3'd1, 16'h0000, 16'h0001, 4'd7},  // R7 other bit kept
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0000, 4'd9},
    '{K_SOCC, 3'd5, 3'd0, 16'h000C, 16'h0000, 4'd5},
    '{K_RD,   3'd5, 3'd1, 16'h0000, 16'h0001, 4'd5},  // R5 no repeat
    '{K_SOCC, 3'd5, 3'd0, 16'h0003, 16'h0000, 4'd6},
    '{K_RD,   3'd5, 3'd1, 16'h0000, 16'h0005, 4'd6},  // R6
    '{K_WR,   3'd1, 3'd4, 16'h0502, 16'h0000, 4'd2},
    '{K_DOCC, 3'd1, 3'd0, 16'h0005, 16'h0000, 4'd5},
    '{K_RD,   3'd1, 3'd1, 16'h0000, 16'h0008, 4'd5},  // R5 destination
    '{K_DOCC, 3'd1, 3'd0, 16'h0002, 16'h0000, 4'd6},
    '{K_RD,   3'd1, 3'd1, 16'h0000, 16'h0018, 4'd6},  // R6 destination
    '{K_ERR,  3'd7, 3'd0, 16'h0000, 16'h0000, 4'd4},
    '{K_RD,   3'd7, 3'd1, 16'h0000, 16'h0020, 4'd4},  // R4
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0000, 4'd9},
    '{K_WR,   3'd7, 3'd2, 16'h0001, 16'h0000, 4'd9},
    '{K_RD,   3'd7, 3'd2, 16'h0000, 16'h0001, 4'd2},
    '{K_SUM,  3'd0, 3'd0, 16'h0000, 16'h0080, 4'd9},  // R9 error gate
    '{K_RD,   3'd7, 3'd6, 16'h0000, 16'h0000, 4'd2},  // R2 unused select
    '{K_WR,   3'd1, 3'd1, 16'h003F, 16'h0000, 4'd7},
    '{K_RD,   3'd1, 3'd1, 16'h0000, 16'h0000, 4'd7}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int eng, input int sel, input logic [15:0] d);
    reg_addr  = AW'((eng << 3) | sel);
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input int eng, input int sel, output logic [15:0] v);
    reg_addr = AW'((eng << 3) | sel);
    #1;
    v = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(summary == '0, "R1 summary", summary, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rd(0, 0, v); check(v == 16'h0, "R1 enable", v, 0);
    rd(3, 1, v); check(v == 16'h0, "R1 status", v, 0);
    rd(6, 2, v); check(v == 16'h0, "R1 error enable", v, 0);
    rd(4, 3, v); check(v == 16'hFF00, "R1 watermark", v, 16'hFF00);

    for (int i = 0; i < NSTEP; i++) begin
      step_t s;
      string tag;
      s = TBL[i];
      tag = $sformatf("R%0d step %0d", s.req, i);
      case (s.kind)
        K_WR: wr(s.eng, s.sel, s.data);
        K_RD: begin
          rd(s.eng, s.sel, v);
          check(v == s.exp, tag, v, s.exp);
        end
        K_DONE: begin
          done_pulse[s.eng] = 1'b1; @(negedge clk); done_pulse = '0;
        end
        K_ERR: begin
          err_pulse[s.eng] = 1'b1; @(negedge clk); err_pulse = '0;
        end
        K_SOCC: begin
          src_occ[s.eng*OW +: OW] = s.data[OW-1:0]; @(negedge clk);
        end
        K_DOCC: begin
          dst_occ[s.eng*OW +: OW] = s.data[OW-1:0]; @(negedge clk);
        end
        default: check(summary == s.exp[NE-1:0], tag, summary, s.exp);
      endcase
    end

    // R10 shared line lags summary by one clock
    check(irq == 1'b1, "R10 irq high", irq, 1);
    wr(7, 1, 16'h0020);
    check(summary == '0, "R10 summary cleared", summary, 0);
    check(irq == 1'b1, "R10 irq still high", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R10 irq dropped", irq, 0);

    // R8 event and clear in the same cycle
    done_pulse[3] = 1'b1;
    wr(3, 1, 16'h0001);
    done_pulse = '0;
    rd(3, 1, v); check(v == 16'h0001, "R8 set wins", v, 1);

    // R7 writing ones to a clear status never sets bits
    wr(0, 1, 16'h003F);
    rd(0, 1, v); check(v == 16'h0, "R7 no set by write", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule